// File: doc/BRIEF.md
# Warp memory access coalescer

This block turns one warp-wide memory instruction into the smallest set of line-sized memory requests. It takes one address per lane, together with a mask that marks which lanes take part. It then issues one request for each distinct 128-byte aligned line that the active lanes touch. Each request carries the line number and the set of lanes it serves. A warp whose active lanes all fall in one line costs one request. A warp whose lanes are spread across many lines costs one request per line, up to one per lane.

The warp issue logic hands a warp over with a valid/ready pair. The coalescer then works through the warp one request at a time. At each step the lowest-numbered lane that is still waiting picks the line. Every waiting lane that maps to the same line is served in that step. Requests leave on a valid/ready port that feeds the L1 request queue. When every active lane has been served, a one-cycle completion pulse appears together with the number of requests that were issued.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `in_ready` is 1 and `req_valid`, `done` and `txn_count` are 0.
- R2: A warp is taken only on a cycle where `in_valid` and `in_ready` are both 1. While a warp is in progress `in_ready` is 0, and any `in_valid` offered then has no effect on the requests that follow.
- R3: The line of each request is address bits [ADDR_W-1:7] of the lowest-numbered lane that is still waiting. Lane i occupies `in_addr[32*i +: 32]`.
- R4: The mask of each request has bit i set exactly when lane i is still waiting and its line equals the request line. Over one warp, each active lane appears in exactly one request mask.
- R5: A warp whose active lanes all lie in one aligned 128-byte line produces a single request whose mask equals the active mask.
- R6: A lane whose `in_active` bit is 0 never appears in a request mask, and its address never causes a request.
- R7: A warp with an all-zero active mask issues no request. `done` is 1 in the cycle after acceptance, with `txn_count` equal to 0.
- R8: While `req_valid` is 1 and `req_ready` is 0, the request stays valid with an unchanged line and mask. Progress happens only on a handshake.
- R9: `done` is a one-cycle pulse in the cycle after the final handshake. In that cycle `txn_count` equals the number of handshakes for the warp, `in_ready` is 1 and `req_valid` is 0.
- R10: A warp whose active lanes all fall in different lines produces one request per lane, in ascending lane order, with a single-bit mask each time. A full 32-lane warp gives a count of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A warp is offered |
| in_ready | output | 1 | The coalescer can take a warp |
| in_active | input | LANES | Per-lane participation mask |
| in_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane 0 in the low bits |
| req_valid | output | 1 | A line request is presented |
| req_ready | input | 1 | Downstream takes the request |
| req_line | output | ADDR_W-7 | Line number (address bits above the line offset) |
| req_mask | output | LANES | Lanes served by this request |
| done | output | 1 | One-cycle pulse when the warp is fully served |
| txn_count | output | $clog2(LANES+1) | Requests issued for the last warp, valid with `done` |

## Verification
The bench builds the block with its defaults: 32 lanes, 32-bit addresses and 128-byte lines. This brings the full 32-bit lane mask and the worst case of 32 separate requests within reach, as well as a count that reaches its top value. Random warps draw their addresses from a handful of nearby lines, so that lines are shared and interleave in non-trivial ways. Back-pressure of random length is applied to every request. Directed warps cover the contiguous case, the empty mask, the fully scattered case, a lone top lane and lanes with identical addresses.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {
    CO_IDLE = 1'b0,
    CO_BUSY = 1'b1
  } coal_state_e;
endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
  parameter int LANES = 32,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic [IDX_W-1:0] lead
);
  // lowest set bit wins; scan downward so the last hit is the lowest lane
  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) lead = IDX_W'(i);
    end
  end
endmodule

// File: rtl/coal_match.sv
module coal_match #(
  parameter int LANES  = 32,
  parameter int LINE_W = 25
) (
  input  logic [LANES*LINE_W-1:0] lines,
  input  logic [LANES-1:0]        pend,
  input  logic [LINE_W-1:0]       sel_line,
  output logic [LANES-1:0]        hit
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = pend[g] && (lines[g*LINE_W +: LINE_W] == sel_line);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFS_W,
  localparam int IDX_W  = $clog2(LANES),
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES-1:0]        in_active,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [LINE_W-1:0]       req_line,
  output logic [LANES-1:0]        req_mask,
  output logic                    done,
  output logic [CNT_W-1:0]        txn_count
);
  coal_state_e               st_q, st_d;
  logic [LANES-1:0]          pend_q, pend_d;
  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic                      done_q, done_d;
  logic [LANES*LINE_W-1:0]   lines_q, in_lines;
  logic [LANES-1:0]          ofs_par, hit, rest;
  logic [IDX_W-1:0]          lead;
  logic                      accept, fire, lines_en;
  logic                      ofs_unused;

  // keep only the line number of each lane; the byte offset is dropped
  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign in_lines[g*LINE_W +: LINE_W] = in_addr[g*ADDR_W + OFS_W +: LINE_W];
    assign ofs_par[g] = ^in_addr[g*ADDR_W +: OFS_W];
  end
  assign ofs_unused = ^ofs_par;

  coal_leader #(.LANES(LANES)) u_leader (
    .pend (pend_q),
    .lead (lead)
  );

  assign req_line = lines_q[lead*LINE_W +: LINE_W];

  coal_match #(.LANES(LANES), .LINE_W(LINE_W)) u_match (
    .lines    (lines_q),
    .pend     (pend_q),
    .sel_line (req_line),
    .hit      (hit)
  );

  assign in_ready  = (st_q == CO_IDLE);
  assign req_valid = (st_q == CO_BUSY);
  assign req_mask  = hit;
  assign done      = done_q;
  assign txn_count = cnt_q;
  assign accept    = in_valid && in_ready;
  assign fire      = req_valid && req_ready;
  assign rest      = pend_q & ~hit;
  assign lines_en  = accept;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (accept) begin
      pend_d = in_active;
      cnt_d  = '0;
      if (in_active == '0) done_d = 1'b1;
      else                 st_d   = CO_BUSY;
    end else if (fire) begin
      pend_d = rest;
      cnt_d  = cnt_q + CNT_W'(1);
      if (rest == '0) begin
        done_d = 1'b1;
        st_d   = CO_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CO_IDLE;
      pend_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lines_en) lines_q <= in_lines;
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_line) && $stable(req_mask));

  // R4
  served_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pend_q & $past(req_mask)) == '0);

  // R6
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_mask != '0);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready && !req_valid);

  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> txn_count <= CNT_W'(LANES));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(pend_q));
endmodule

// File: tb/sim_warp_coalescer.sv
module sim_warp_coalescer;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int LW    = AW - 7;
  localparam int CW    = $clog2(LANES + 1);
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES-1:0] in_active = '0;
  logic [LANES*AW-1:0] in_addr = '0;
  logic req_valid;
  logic req_ready = 1'b0;
  logic [LW-1:0] req_line;
  logic [LANES-1:0] req_mask;
  logic done;
  logic [CW-1:0] txn_count;

  int n_chk = 0;
  int n_bad = 0;
  logic [AW-1:0] a [LANES];

  always #(TCLK/2) clk = ~clk;

  warp_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_active(in_active), .in_addr(in_addr), .req_valid(req_valid),
    .req_ready(req_ready), .req_line(req_line), .req_mask(req_mask),
    .done(done), .txn_count(txn_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] line_of(input int i);
    return a[i][AW-1:7];
  endfunction

  // offers a warp, then walks the expected request sequence with back-pressure
  task automatic run_warp(input logic [LANES-1:0] act, input bit poke_busy);
    logic [LANES-1:0] pend, msk;
    logic [LW-1:0] ln;
    int lead, n, stall;
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready before offer", in_ready, 1);
    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = a[i];
    in_active = act;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (act == '0) begin
      check(done == 1'b1, "R7 done", done, 1);
      check(txn_count == '0, "R7 count", txn_count, 0);
      check(req_valid == 1'b0, "R7 no request", req_valid, 0);
      return;
    end
    pend = act;
    n = 0;
    while (pend != '0) begin
      lead = 0;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
      ln = line_of(lead);
      msk = '0;
      for (int i = 0; i < LANES; i++) if (pend[i] && line_of(i) == ln) msk[i] = 1'b1;
      stall = int'($urandom_range(0, 2));
      for (int s = 0; s < stall; s++) begin
        if (poke_busy && n == 0 && s == 0) begin
          in_valid  = 1'b1;
          in_active = ~act;
          in_addr   = ~in_addr;
        end
        check(in_ready == 1'b0, "R2 busy", in_ready, 0);
        check(req_valid == 1'b1 && req_line == ln, "R8 held line", req_line, ln);
        check(req_mask == msk, "R8 held mask", req_mask, msk);
        @(negedge clk);
        in_valid = 1'b0;
      end
      req_ready = 1'b1;
      check(req_valid == 1'b1, "R3 valid", req_valid, 1);
      check(req_line == ln, "R3 line", req_line, ln);
      check(req_mask == msk, "R4 mask", req_mask, msk);
      check((req_mask & ~act) == '0, "R6 inactive lane", req_mask, msk);
      check(done == 1'b0, "R9 no early done", done, 0);
      @(negedge clk);
      req_ready = 1'b0;
      pend &= ~msk;
      n++;
    end
    check(done == 1'b1, "R9 done pulse", done, 1);
    check(txn_count == CW'(n), "R9 count", txn_count, n);
    check(in_ready == 1'b1 && req_valid == 1'b0, "R9 idle", {in_ready, req_valid}, 2);
    @(negedge clk);
    check(done == 1'b0, "R9 single pulse", done, 0);
  endtask

  initial begin
    #(TCLK * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [AW-1:0] base;
    void'($urandom(32'd4242));
    #(TCLK * 2);
    @(negedge clk);
    // R1
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    check(req_valid == 1'b0 && done == 1'b0, "R1 idle", {req_valid, done}, 0);
    check(txn_count == '0, "R1 count", txn_count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 contiguous aligned warp
    base = 32'h0004_0000;
    for (int i = 0; i < LANES; i++) a[i] = base + 32'(4 * i);
    run_warp('1, 1'b1);
    check(1'b1, "R5 contiguous", 0, 0);

    // R7 empty mask
    run_warp('0, 1'b0);

    // R10 fully scattered, ascending order
    for (int i = 0; i < LANES; i++) a[i] = 32'h0100_0000 + 32'((LANES - i) * 384);
    run_warp('1, 1'b0);

    // R6 lone top lane, other lanes on distinct lines
    for (int i = 0; i < LANES; i++) a[i] = 32'(i * 4096);
    run_warp(32'h8000_0000, 1'b0);

    // R4 identical addresses on odd lanes, scattered evens
    for (int i = 0; i < LANES; i++) a[i] = (i % 2 == 1) ? 32'h00AB_CD40 : 32'(i * 256 + 3);
    run_warp(32'hF0F0_F0F3, 1'b1);

    // R3 random warps over a few nearby lines
    for (int w = 0; w < 60; w++) begin
      base = $urandom & 32'hFFFF_FF80;
      for (int i = 0; i < LANES; i++)
        a[i] = base + 32'($urandom_range(0, 4) * 128) + 32'($urandom_range(0, 127));
      run_warp(32'($urandom) & 32'($urandom | (w % 3 == 0 ? 32'hFFFF_FFFF : 32'h0)), w % 5 == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule